// File: doc/BRIEF.md
# AHB-to-APB Bridge

This block is a single slave on a pipelined high-performance system bus (AHB). It turns each transfer addressed to it into a transfer on a low-power peripheral bus (APB), which serves up to four register-mapped peripherals. In the address phase the bridge samples the address, direction and transfer type. It then holds the bus ready signal low while the peripheral access runs. When the access is done it hands back the read data and an OKAY response, or it gives a two-cycle ERROR response when the address selects no peripheral.

On the peripheral side the bridge latches the write data during the data phase. It then runs one SETUP cycle with a select line high and the enable strobe low. This is followed by one ENABLE cycle with the strobe high and the address, direction and select held unchanged. A new transfer can be accepted in the cycle in which the previous one completes. Idle and busy transfer types complete at once, with no wait states.

Top module: `ahb_apb_bridge`

## Requirements
- R1: During and right after reset, `hready_out` is 1, `hresp` is OKAY (2'b00), `psel` is all zero and `penable` is 0.
- R2: A selected address phase with `htrans` IDLE (2'b00) or BUSY (2'b01) completes with no wait state. In the next cycle `hready_out` is 1 and `hresp` is OKAY, and no `psel` line rises.
- R3: An address phase with `hsel` low, or with `hready_in` low, is ignored. `hready_out` stays 1 and no `psel` line rises.
- R4: A selected NONSEQ (2'b10) or SEQ (2'b11) address phase whose field `haddr[15:12]` holds a value from 0 to 3 causes a SETUP cycle in the second cycle after the address phase. In that cycle `psel[haddr[15:12]]` alone is 1, `penable` is 0, `paddr` equals the sampled `haddr`, and `pwrite` equals the sampled `hwrite`.
- R5: The cycle after SETUP is ENABLE, and it lasts one cycle. In it `penable` is 1, and `psel`, `paddr` and `pwrite` are unchanged from SETUP.
- R6: `pwdata` equals the `hwdata` driven in the cycle after the address phase. It holds that value through SETUP and ENABLE, whatever `hwdata` does afterwards.
- R7: `hready_out` is 0 from the cycle after the address phase through ENABLE. In the cycle after ENABLE, `hready_out` is 1, `hresp` is OKAY, `psel` and `penable` are 0, and for a read `hrdata` equals the `prdata` present during ENABLE.
- R8: A NONSEQ or SEQ address phase with `haddr[15:12]` from 4 to 15 gets ERROR (2'b01) over two cycles. The first has `hready_out` 0, the second has `hready_out` 1, and no `psel` line rises.
- R9: An address phase presented in the completion cycle of a previous transfer is accepted and starts its own transfer with the same timing.
- R10: At most one `psel` line is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the system-bus decoder |
| haddr | input | 32 | System-bus address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus-wide ready; an address phase counts only when it is 1 |
| hready_out | output | 1 | This slave's ready; 0 inserts wait states |
| hresp | output | 2 | Response: 00 OKAY, 01 ERROR |
| hrdata | output | 32 | Read data returned to the master |
| psel | output | 4 | One select line per peripheral |
| penable | output | 1 | Peripheral enable strobe, high in ENABLE |
| paddr | output | 32 | Peripheral address |
| pwrite | output | 1 | Peripheral direction |
| pwdata | output | 32 | Peripheral write data |
| prdata | input | 32 | Read data from the selected peripheral |

## Verification
The assertions assume that `hready_in` follows the bridge's own `hready_out` whenever the bridge is the slave in its data phase. They therefore do not check what happens if a master issues an address while the bridge is stalling. The bench wires `hready_in` to `hready_out` and pulls it low only while the bridge is idle, to test that the address phase is ignored. It changes `hsel`, `htrans` and `haddr` only on falling edges, and only in cycles where the bridge can accept an address. It also scrambles `hwdata` after the data phase, so that a late capture would show up on `pwdata`.

// File: rtl/apbbr_pkg.sv
package apbbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_SETUP,
        ST_ENABLE,
        ST_DONE,
        ST_ERR1,
        ST_ERR2
    } brg_state_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] RSP_OKAY  = 2'b00;
    localparam logic [1:0] RSP_ERROR = 2'b01;

endpackage

// File: rtl/apbbr_slot_decode.sv
// Maps the slot field of the address to a peripheral index and flags
// field values that have no peripheral behind them (R4, R8).
module apbbr_slot_decode #(
    parameter int SLOT_BITS = 4,
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [SLOT_BITS-1:0] field,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    localparam logic [SLOT_BITS:0] LIMIT = (SLOT_BITS+1)'(NUM_SLOTS);

    always_comb begin
        hit = ({1'b0, field} < LIMIT);
        idx = field[IDX_W-1:0];
    end
endmodule

// File: rtl/apbbr_sel_fanout.sv
// Turns the stored index into one select line per peripheral (R4, R10).
module apbbr_sel_fanout #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 active,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_SLOTS-1:0] sel
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_line
        assign sel[g] = active && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import apbbr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_LSB  = 12,
    parameter int SLOT_BITS = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsel,
    input  logic [ADDR_W-1:0]    haddr,
    input  logic [1:0]           htrans,
    input  logic                 hwrite,
    input  logic [DATA_W-1:0]    hwdata,
    input  logic                 hready_in,
    output logic                 hready_out,
    output logic [1:0]           hresp,
    output logic [DATA_W-1:0]    hrdata,
    output logic [NUM_SLOTS-1:0] psel,
    output logic                 penable,
    output logic [ADDR_W-1:0]    paddr,
    output logic                 pwrite,
    output logic [DATA_W-1:0]    pwdata,
    input  logic [DATA_W-1:0]    prdata
);

    typedef struct packed {
        brg_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } brg_regs_t;

    brg_regs_t r_q, r_d;

    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             ready_now;
    logic             xfer_type;
    logic             accept;
    logic             apb_active;

    apbbr_slot_decode #(
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .field (haddr[SLOT_LSB +: SLOT_BITS]),
        .hit   (dec_hit),
        .idx   (dec_idx)
    );

    // Ready only in states where no data phase is pending (R2, R7, R8).
    assign ready_now  = (r_q.state == ST_IDLE) || (r_q.state == ST_DONE) ||
                        (r_q.state == ST_ERR2);
    assign xfer_type  = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);
    // Deselected or stalled address phases do nothing (R3).
    assign accept     = hsel && hready_in && xfer_type && ready_now;
    assign apb_active = (r_q.state == ST_SETUP) || (r_q.state == ST_ENABLE);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_DONE, ST_ERR2: begin
                if (accept) begin
                    r_d.addr  = haddr;
                    r_d.write = hwrite;
                    r_d.idx   = dec_idx;
                    r_d.state = dec_hit ? ST_LATCH : ST_ERR1;   // R4, R8
                end else begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_LATCH: begin
                if (r_q.write) begin
                    r_d.wdata = hwdata;                         // R6
                end
                r_d.state = ST_SETUP;
            end
            ST_SETUP:  r_d.state = ST_ENABLE;                   // R5
            ST_ENABLE: begin
                if (!r_q.write) begin
                    r_d.rdata = prdata;                         // R7
                end
                r_d.state = ST_DONE;
            end
            ST_ERR1:   r_d.state = ST_ERR2;                     // R8
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, write: 1'b0, idx: '0,
                     wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    apbbr_sel_fanout #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fanout (
        .active (apb_active),
        .idx    (r_q.idx),
        .sel    (psel)
    );

    assign hready_out = ready_now;
    assign hresp      = ((r_q.state == ST_ERR1) || (r_q.state == ST_ERR2)) ?
                        RSP_ERROR : RSP_OKAY;
    assign hrdata     = r_q.rdata;
    assign penable    = (r_q.state == ST_ENABLE);
    assign paddr      = r_q.addr;
    assign pwrite     = r_q.write;
    assign pwdata     = r_q.wdata;

    AST_SETUP_THEN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|psel) && !penable) |=> (penable && psel == $past(psel) &&
        paddr == $past(paddr) && pwrite == $past(pwrite))); // R5

    AST_ENABLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        penable |=> (!penable && psel == '0 && hready_out && hresp == RSP_OKAY)); // R7

    AST_STALL_DURING_APB: assert property (@(posedge clk) disable iff (!rst_n)
        (|psel) |-> !hready_out); // R7

    AST_PWDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> $stable(pwdata)); // R6

    AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp == RSP_ERROR && !hready_out) |=> (hresp == RSP_ERROR && hready_out)); // R8

    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp == RSP_ERROR) |-> (psel == '0)); // R8

    AST_IDLE_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready_in && hready_out && !htrans[1]) |=>
        (hready_out && hresp == RSP_OKAY && psel == '0)); // R2

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel)); // R10

endmodule

// File: tb/tb_ahb_apb_bridge.sv
module tb_ahb_apb_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hsel;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [31:0] hwdata;
    logic        hready_in;
    logic        hready_out;
    logic [1:0]  hresp;
    logic [31:0] hrdata;
    logic [3:0]  psel;
    logic        penable;
    logic [31:0] paddr;
    logic        pwrite;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        stall_force;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign hready_in = stall_force ? 1'b0 : hready_out;

    ahb_apb_bridge dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready_in(hready_in),
        .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata), .psel(psel),
        .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .prdata(prdata)
    );

    // kind: 0 = no peripheral access, 1 = peripheral access, 2 = error
    // fields: trans[100:99] write[98] addr[97:66] wdata[65:34] prdata[33:2] kind[1:0]
    localparam int NV = 10;
    localparam logic [100:0] VECS [NV] = '{
        {2'b10, 1'b1, 32'h0000_0010, 32'hA5A5_0001, 32'h0000_0000, 2'd1},
        {2'b11, 1'b0, 32'h0000_1024, 32'h0000_0000, 32'h1234_5678, 2'd1},
        {2'b10, 1'b1, 32'h0000_3FFC, 32'hFFFF_0000, 32'h0000_0000, 2'd1},
        {2'b00, 1'b1, 32'h0000_1000, 32'h1111_1111, 32'h0000_0000, 2'd0},
        {2'b01, 1'b0, 32'h0000_2000, 32'h0000_0000, 32'h0000_0000, 2'd0},
        {2'b10, 1'b0, 32'h0000_4000, 32'h0000_0000, 32'h5555_5555, 2'd2},
        {2'b10, 1'b1, 32'h0001_F008, 32'h7777_7777, 32'h0000_0000, 2'd2},
        {2'b10, 1'b0, 32'h0000_2008, 32'h0000_0000, 32'hDEAD_BEEF, 2'd1},
        {2'b11, 1'b1, 32'hABCD_2010, 32'h0BAD_F00D, 32'h0000_0000, 2'd1},
        {2'b10, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0001, 2'd1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge with the bridge ready; drives the address phase.
    task automatic xfer(input logic [1:0] tr, input logic wr, input logic [31:0] ad,
                        input logic [31:0] wd, input logic [31:0] pr,
                        input logic [1:0] kind);
        logic [3:0] exp_sel;
        exp_sel = 4'b0001 << ad[13:12];
        hsel = 1'b1; htrans = tr; hwrite = wr; haddr = ad; prdata = pr;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        if (kind == 2'd0) begin
            chk("R2", "ready", 32'(hready_out), 32'd1);
            chk("R2", "resp", 32'(hresp), 32'd0);
            chk("R2", "psel", 32'(psel), 32'd0);
        end else if (kind == 2'd2) begin
            chk("R8", "ready1", 32'(hready_out), 32'd0);
            chk("R8", "resp1", 32'(hresp), 32'd1);
            chk("R8", "psel1", 32'(psel), 32'd0);
            @(negedge clk);
            chk("R8", "ready2", 32'(hready_out), 32'd1);
            chk("R8", "resp2", 32'(hresp), 32'd1);
            chk("R8", "psel2", 32'(psel), 32'd0);
            @(negedge clk);
            chk("R8", "resp_after", 32'(hresp), 32'd0);
        end else begin
            chk("R7", "ready_data", 32'(hready_out), 32'd0);
            chk("R4", "psel_data", 32'(psel), 32'd0);
            @(negedge clk);
            hwdata = ~wd;
            chk("R4", "setup_psel", 32'(psel), 32'(exp_sel));
            chk("R4", "setup_penable", 32'(penable), 32'd0);
            chk("R4", "setup_paddr", paddr, ad);
            chk("R4", "setup_pwrite", 32'(pwrite), 32'(wr));
            chk("R7", "setup_ready", 32'(hready_out), 32'd0);
            if (wr) chk("R6", "setup_pwdata", pwdata, wd);
            @(negedge clk);
            chk("R5", "enable_penable", 32'(penable), 32'd1);
            chk("R5", "enable_psel", 32'(psel), 32'(exp_sel));
            chk("R5", "enable_paddr", paddr, ad);
            chk("R5", "enable_pwrite", 32'(pwrite), 32'(wr));
            chk("R7", "enable_ready", 32'(hready_out), 32'd0);
            if (wr) chk("R6", "enable_pwdata", pwdata, wd);
            @(negedge clk);
            chk("R7", "done_ready", 32'(hready_out), 32'd1);
            chk("R7", "done_resp", 32'(hresp), 32'd0);
            chk("R7", "done_psel", 32'({penable, psel}), 32'd0);
            if (!wr) chk("R7", "done_hrdata", hrdata, pr);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsel = 1'b0; haddr = '0; htrans = 2'b00; hwrite = 1'b0;
        hwdata = '0; prdata = '0; stall_force = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset_ready", 32'(hready_out), 32'd1);
        chk("R1", "reset_resp", 32'(hresp), 32'd0);
        chk("R1", "reset_psel", 32'({penable, psel}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post_reset_ready", 32'(hready_out), 32'd1);
        chk("R1", "post_reset_psel", 32'({penable, psel}), 32'd0);

        // Table walk: each entry starts in the completion cycle of the last (R9).
        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i][100:99], VECS[i][98], VECS[i][97:66], VECS[i][65:34],
                 VECS[i][33:2], VECS[i][1:0]);
        end

        // R3: deselected address phase
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0000_1000;
        @(negedge clk);
        chk("R3", "nosel_ready", 32'(hready_out), 32'd1);
        chk("R3", "nosel_psel", 32'(psel), 32'd0);
        htrans = 2'b00;
        @(negedge clk);
        chk("R3", "nosel_psel_late", 32'(psel), 32'd0);

        // R3: stalled address phase (bus ready low)
        hsel = 1'b1; htrans = 2'b10; stall_force = 1'b1;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; stall_force = 1'b0;
        chk("R3", "stall_ready", 32'(hready_out), 32'd1);
        chk("R3", "stall_psel", 32'(psel), 32'd0);
        @(negedge clk);
        chk("R3", "stall_psel_late", 32'(psel), 32'd0);

        // R9: back-to-back read then write at highest mapped slot
        xfer(2'b10, 1'b0, 32'h0000_3004, 32'h0, 32'hCAFE_0003, 2'd1);
        xfer(2'b11, 1'b1, 32'h0000_3008, 32'h0102_0304, 32'h0, 2'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule